// File: doc/BRIEF.md
# Switching-Cycle Fault Event Accumulator

This block watches one digital comparator output of a switching power stage, once per switching cycle, and decides when a protection fault is real. In each cycle it looks at the comparator during one gate-drive phase. Comparator activity early in that phase falls inside a programmable blanking window and is ignored. From what remains, the block decides whether the cycle holds a fault event. An up/down count rises by one on an event cycle and falls by one on a clean cycle, so isolated glitches cancel out. A fault is declared when the count reaches a programmable limit.

A compile-time mode selects one of three uses. In overvoltage mode the comparator is sampled while the gate is off. In overcurrent mode it is sampled while the gate is on. In open-loop mode the event is the comparator failing to trip inside a short scan window after blanking. After a fault, the gate-inhibit output is raised and the count is frozen. Depending on a latch setting, the fault then either holds until reset or ends after a programmed restart delay, which re-arms the block with a cleared count. All configuration arrives as static input fields. The gate phase and the comparator are plain sampled inputs, and there is no stream interface and no back-pressure.

Top module: `swc_fault_accum`

## Requirements
- R1: With `cfg_disable` = 1 and no fault active, the count is held at 0 and no fault is declared. The monitor runs only when `cfg_disable` = 0.
- R2: The count changes exactly once per switching cycle, at the clock edge that ends the sampling phase. It rises by 1 if that phase held an event and falls by 1 if it did not. At no other edge does it move, except for the clear on restart (R10).
- R3: The count never wraps. A decrement at 0 leaves 0, and an increment at the all-ones value leaves it there.
- R4: A fault is declared at the same edge as the update whose new count is greater than or equal to `cfg_limit`.
- R5: A comparator pulse in the first `cfg_blank`×BLANK_STEP clock cycles of the sampling phase is ignored. Cycles are numbered from 0 at the first clock of the phase.
- R6: In overvoltage mode the sampling phase is `gate_on` = 0. A qualified trip is an event. The update happens at the first clock with `gate_on` = 1.
- R7: In overcurrent mode the sampling phase is `gate_on` = 1. A qualified trip is an event. The update happens at the first clock with `gate_on` = 0.
- R8: In open-loop mode the sampling phase is `gate_on` = 1. A trip in phase cycles `blank`..`blank`+SCAN_CYC−1 makes the cycle clean, and a cycle with no trip there is an event. Trips outside that window are ignored. The update happens at the first clock with `gate_on` = 0.
- R9: With `cfg_latch` = 1, a declared fault stays asserted, and the count stays frozen, until `rst_n` is asserted.
- R10: With `cfg_latch` = 0, the fault lasts `cfg_restart`×T+1 clock cycles, where T is FAST_TICK for `cfg_slow` = 0 and SLOW_TICK for `cfg_slow` = 1. The count is frozen during that time and reads 0 when the fault ends.
- R11: `gate_inhibit_o` is 1 exactly while `fault_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_disable | input | 1 | 1 turns the monitor off |
| cfg_blank | input | BLANK_W | Blanking length in units of BLANK_STEP cycles |
| cfg_limit | input | LIM_W | Trip limit for the count |
| cfg_latch | input | 1 | 1: fault held until reset; 0: timed restart |
| cfg_restart | input | RST_W | Restart delay in ticks |
| cfg_slow | input | 1 | Selects the long restart tick |
| gate_on | input | 1 | Gate-drive phase from the switching controller |
| cmp_trip | input | 1 | Comparator output |
| evt_count_o | output | CNT_W | Current event count |
| fault_o | output | 1 | Fault declared |
| gate_inhibit_o | output | 1 | Request to keep the gate off |

## Verification
The count is due at the single edge that closes the sampling phase. For overcurrent and open-loop mode that is the first gate-off clock, and for overvoltage mode it is the first gate-on clock of the following cycle. A fault rises at that same edge. The bench drives the gate and comparator on falling edges, a whole switching cycle at a time, and reads results on the falling edge after the phase has closed, so every pending update has already landed. Restart length is measured by counting, on falling edges, the consecutive cycles with `fault_o` high. It is compared against `cfg_restart`×T+1 only after the fault has ended.

// File: rtl/swc_fault_pkg.sv
package swc_fault_pkg;

  typedef enum logic [1:0] {
    MODE_OVP = 2'd0,
    MODE_OCP = 2'd1,
    MODE_OLP = 2'd2
  } mon_mode_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HOLD = 2'd1,
    ST_WAIT = 2'd2
  } flt_state_e;

endpackage

// File: rtl/swc_phase_qual.sv
module swc_phase_qual #(
  parameter swc_fault_pkg::mon_mode_e MODE = swc_fault_pkg::MODE_OCP,
  parameter int BLANK_W    = 3,
  parameter int BLANK_STEP = 2,
  parameter int SCAN_CYC   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gate_on,
  input  logic               cmp_trip,
  input  logic [BLANK_W-1:0] cfg_blank,
  output logic               upd,
  output logic               evt
);
  localparam int PH_MAX = ((1 << BLANK_W) - 1) * BLANK_STEP + SCAN_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  logic            active, active_q, hit, in_win;
  logic [PH_W-1:0] phase_cnt, blank_len;

  assign blank_len = PH_W'(cfg_blank) * PH_W'(BLANK_STEP);

  generate
    if (MODE == swc_fault_pkg::MODE_OVP) begin : g_gate_off
      assign active = ~gate_on;
    end else begin : g_gate_on
      assign active = gate_on;
    end

    if (MODE == swc_fault_pkg::MODE_OLP) begin : g_scan
      logic [PH_W-1:0] scan_end;
      assign scan_end = blank_len + PH_W'(SCAN_CYC);
      assign in_win   = (phase_cnt >= blank_len) && (phase_cnt < scan_end);
      assign evt      = ~hit;
    end else begin : g_level
      assign in_win   = (phase_cnt >= blank_len);
      assign evt      = hit;
    end
  endgenerate

  // phase ends on the first clock the sampling phase is no longer active
  assign upd = active_q & ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      phase_cnt <= '0;
      hit       <= 1'b0;
    end else begin
      active_q <= active;
      if (active) begin
        if (phase_cnt != PH_W'(PH_MAX)) phase_cnt <= phase_cnt + 1'b1;
        hit <= hit | (in_win & cmp_trip);
      end else begin
        phase_cnt <= '0;
        hit       <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/swc_evt_counter.sv
module swc_evt_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             evt,
  input  logic             freeze,
  input  logic             clr,
  input  logic             hold_zero,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_step
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_comb begin
    if (evt) cnt_step = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
    else     cnt_step = (cnt == '0)      ? cnt : cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (freeze)    cnt <= cnt;
    else if (hold_zero) cnt <= '0;
    else if (upd)       cnt <= cnt_step;
  end
endmodule

// File: rtl/swc_restart_ctl.sv
module swc_restart_ctl #(
  parameter int CNT_W     = 3,
  parameter int LIM_W     = 3,
  parameter int RST_W     = 6,
  parameter int FAST_TICK = 4,
  parameter int SLOW_TICK = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_disable,
  input  logic [LIM_W-1:0] cfg_limit,
  input  logic             cfg_latch,
  input  logic [RST_W-1:0] cfg_restart,
  input  logic             cfg_slow,
  input  logic             upd,
  input  logic [CNT_W-1:0] cnt_step,
  output logic             fault,
  output logic             rs_done
);
  import swc_fault_pkg::*;

  localparam int CW   = (CNT_W > LIM_W) ? CNT_W : LIM_W;
  localparam int TK_W = $clog2(SLOW_TICK + 1);

  flt_state_e       state;
  logic [TK_W-1:0]  tick_cnt, tick_last;
  logic [RST_W-1:0] rs_cnt;
  logic             trip;

  assign tick_last = cfg_slow ? TK_W'(SLOW_TICK - 1) : TK_W'(FAST_TICK - 1);
  assign trip      = (state == ST_RUN) & upd & ~cfg_disable &
                     (CW'(cnt_step) >= CW'(cfg_limit));
  assign rs_done   = (state == ST_WAIT) && (rs_cnt == cfg_restart);
  assign fault     = (state != ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      tick_cnt <= '0;
      rs_cnt   <= '0;
    end else begin
      unique case (state)
        ST_RUN: begin
          tick_cnt <= '0;
          rs_cnt   <= '0;
          if (trip) state <= cfg_latch ? ST_HOLD : ST_WAIT;
        end
        ST_HOLD: state <= ST_HOLD;
        ST_WAIT: begin
          if (rs_done) begin
            state <= ST_RUN;
          end else if (tick_cnt == tick_last) begin
            tick_cnt <= '0;
            rs_cnt   <= rs_cnt + 1'b1;
          end else begin
            tick_cnt <= tick_cnt + 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/swc_fault_accum.sv
module swc_fault_accum #(
  parameter swc_fault_pkg::mon_mode_e MODE = swc_fault_pkg::MODE_OCP,
  parameter int CNT_W      = 3,
  parameter int LIM_W      = 3,
  parameter int BLANK_W    = 3,
  parameter int RST_W      = 6,
  parameter int BLANK_STEP = 2,
  parameter int SCAN_CYC   = 5,
  parameter int FAST_TICK  = 4,
  parameter int SLOW_TICK  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_disable,
  input  logic [BLANK_W-1:0] cfg_blank,
  input  logic [LIM_W-1:0]   cfg_limit,
  input  logic               cfg_latch,
  input  logic [RST_W-1:0]   cfg_restart,
  input  logic               cfg_slow,
  input  logic               gate_on,
  input  logic               cmp_trip,
  output logic [CNT_W-1:0]   evt_count_o,
  output logic               fault_o,
  output logic               gate_inhibit_o
);
  logic             upd, evt, rs_done;
  logic [CNT_W-1:0] cnt_step;

  swc_phase_qual #(
    .MODE(MODE), .BLANK_W(BLANK_W), .BLANK_STEP(BLANK_STEP), .SCAN_CYC(SCAN_CYC)
  ) u_qual (
    .clk(clk), .rst_n(rst_n), .gate_on(gate_on), .cmp_trip(cmp_trip),
    .cfg_blank(cfg_blank), .upd(upd), .evt(evt)
  );

  swc_evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .upd(upd), .evt(evt), .freeze(fault_o),
    .clr(rs_done), .hold_zero(cfg_disable), .cnt(evt_count_o), .cnt_step(cnt_step)
  );

  swc_restart_ctl #(
    .CNT_W(CNT_W), .LIM_W(LIM_W), .RST_W(RST_W),
    .FAST_TICK(FAST_TICK), .SLOW_TICK(SLOW_TICK)
  ) u_rst (
    .clk(clk), .rst_n(rst_n), .cfg_disable(cfg_disable), .cfg_limit(cfg_limit),
    .cfg_latch(cfg_latch), .cfg_restart(cfg_restart), .cfg_slow(cfg_slow),
    .upd(upd), .cnt_step(cnt_step), .fault(fault_o), .rs_done(rs_done)
  );

  assign gate_inhibit_o = fault_o;
endmodule

// File: rtl/swc_fault_accum_chk.sv
module swc_fault_accum_chk #(
  parameter int CNT_W = 3,
  parameter int LIM_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_disable,
  input logic [LIM_W-1:0] cfg_limit,
  input logic             cfg_latch,
  input logic             upd,
  input logic             evt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cnt_step,
  input logic             fault,
  input logic             rs_done
);
  localparam int CW = (CNT_W > LIM_W) ? CNT_W : LIM_W;

  p_quiet_between_updates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !rs_done && !cfg_disable) |=> $stable(cnt));

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !fault && !cfg_disable && evt && cnt != {CNT_W{1'b1}})
      |=> cnt == $past(cnt) + 1'b1);

  p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !fault && !cfg_disable && !evt && cnt == '0) |=> cnt == '0);

  p_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !fault && !cfg_disable && (CW'(cnt_step) >= CW'(cfg_limit))) |=> fault);

  p_latched_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && cfg_latch) |=> fault);

  p_frozen_then_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> ((fault && $stable(cnt)) || (!fault && cnt == '0)));

  p_disabled_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_disable && !fault) |=> (!fault && cnt == '0));
endmodule

bind swc_fault_accum swc_fault_accum_chk #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_disable(cfg_disable), .cfg_limit(cfg_limit),
  .cfg_latch(cfg_latch), .upd(upd), .evt(evt), .cnt(evt_count_o),
  .cnt_step(cnt_step), .fault(fault_o), .rs_done(rs_done)
);

// File: tb/test_swc_fault_accum.sv
module test_swc_fault_accum;
  import swc_fault_pkg::*;

  localparam int CLK_P   = 10;
  localparam int ON_LEN  = 10;
  localparam int OFF_LEN = 8;
  localparam int NONE    = 15;
  localparam int N_VEC   = 8;
  // t_on, t_off, expected overcurrent, overvoltage, open-loop counts
  // cfg_blank=1 -> blank 2 cycles; open-loop scan window = phase cycles 2..6
  localparam int VEC [N_VEC][5] = '{
    '{15, 15, 0, 0, 1},   // no trips: open-loop event (R8)
    '{ 3,  4, 1, 0, 0},   // R7 event, R8 trip in window, R3 floor for R6
    '{ 1,  1, 0, 1, 1},   // R5 both trips blanked; R6 event from prior off phase
    '{ 8,  2, 1, 0, 2},   // R8 trip after scan window ignored
    '{ 2,  7, 2, 1, 1},   // R5 first unblanked cycle counts
    '{ 6,  0, 3, 2, 0},   // R8 last scan cycle counts
    '{ 7,  3, 4, 1, 1},   // R6 off trip at 0 blanked
    '{15, 15, 3, 2, 2}    // R2 clean cycle decrements
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_disable = 1'b0, cfg_latch = 1'b0, cfg_slow = 1'b0;
  logic [2:0] cfg_blank = 3'd1, cfg_limit = 3'd7;
  logic [5:0] cfg_restart = 6'd0;
  logic       gate_on = 1'b0, cmp_trip = 1'b0;
  logic [2:0] cnt_ocp, cnt_ovp, cnt_olp;
  logic       f_ocp, f_ovp, f_olp, inh_ocp, inh_ovp, inh_olp;
  int n_chk = 0, n_err = 0, run_len = 0, last_len = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  swc_fault_accum #(.MODE(MODE_OCP)) i_swc_fault_accum (
    .clk(clk), .rst_n(rst_n), .cfg_disable(cfg_disable), .cfg_blank(cfg_blank),
    .cfg_limit(cfg_limit), .cfg_latch(cfg_latch), .cfg_restart(cfg_restart),
    .cfg_slow(cfg_slow), .gate_on(gate_on), .cmp_trip(cmp_trip),
    .evt_count_o(cnt_ocp), .fault_o(f_ocp), .gate_inhibit_o(inh_ocp));

  swc_fault_accum #(.MODE(MODE_OVP)) i_swc_fault_accum_ovp (
    .clk(clk), .rst_n(rst_n), .cfg_disable(cfg_disable), .cfg_blank(cfg_blank),
    .cfg_limit(cfg_limit), .cfg_latch(cfg_latch), .cfg_restart(cfg_restart),
    .cfg_slow(cfg_slow), .gate_on(gate_on), .cmp_trip(cmp_trip),
    .evt_count_o(cnt_ovp), .fault_o(f_ovp), .gate_inhibit_o(inh_ovp));

  swc_fault_accum #(.MODE(MODE_OLP)) i_swc_fault_accum_olp (
    .clk(clk), .rst_n(rst_n), .cfg_disable(cfg_disable), .cfg_blank(cfg_blank),
    .cfg_limit(cfg_limit), .cfg_latch(cfg_latch), .cfg_restart(cfg_restart),
    .cfg_slow(cfg_slow), .gate_on(gate_on), .cmp_trip(cmp_trip),
    .evt_count_o(cnt_olp), .fault_o(f_olp), .gate_inhibit_o(inh_olp));

  // length of the most recent overcurrent fault episode, in clock cycles
  always @(negedge clk) begin
    if (f_ocp) run_len = run_len + 1;
    else if (run_len != 0) begin
      last_len = run_len;
      run_len  = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic dis, input logic [2:0] lim, input logic lat,
                          input logic [5:0] rst_ticks, input logic slow);
    @(negedge clk);
    rst_n = 1'b0; gate_on = 1'b0; cmp_trip = 1'b0;
    cfg_disable = dis; cfg_limit = lim; cfg_latch = lat;
    cfg_restart = rst_ticks; cfg_slow = slow; cfg_blank = 3'd1;
    @(posedge clk);
    run_len = 0; last_len = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_cycle(input int t_on, input int t_off);
    for (int k = 0; k < ON_LEN; k++) begin
      @(negedge clk); gate_on = 1'b1; cmp_trip = (k == t_on);
    end
    for (int k = 0; k < OFF_LEN; k++) begin
      @(negedge clk); gate_on = 1'b0; cmp_trip = (k == t_off);
    end
    @(negedge clk); cmp_trip = 1'b0;
  endtask

  task automatic restart_case(input logic [5:0] ticks, input logic slow, input int exp_len,
                              input string tag);
    do_reset(1'b0, 3'd1, 1'b0, ticks, slow);
    run_cycle(5, NONE);
    repeat (exp_len + 20) @(negedge clk);
    chk({"R10 fault length ", tag}, last_len, exp_len);
    chk({"R10 count cleared ", tag}, cnt_ocp, 0);
    chk({"R10 fault released ", tag}, f_ocp, 0);
  endtask

  initial begin
    // reset state
    do_reset(1'b0, 3'd7, 1'b0, 6'd0, 1'b0);
    @(negedge clk);
    chk("R2 reset count ocp", cnt_ocp, 0);
    chk("R2 reset count ovp", cnt_ovp, 0);
    chk("R2 reset count olp", cnt_olp, 0);
    chk("R4 reset no fault", f_ocp | f_ovp | f_olp, 0);

    // vector walk: R2 R3 R5 R6 R7 R8
    for (int v = 0; v < N_VEC; v++) begin
      run_cycle(VEC[v][0], VEC[v][1]);
      chk($sformatf("R7 overcurrent count vec %0d", v), cnt_ocp, VEC[v][2]);
      chk($sformatf("R6 overvoltage count vec %0d", v), cnt_ovp, VEC[v][3]);
      chk($sformatf("R8 open-loop count vec %0d", v), cnt_olp, VEC[v][4]);
    end

    // latched fault: R4 R9 R11
    do_reset(1'b0, 3'd2, 1'b1, 6'd0, 1'b0);
    run_cycle(5, NONE);
    chk("R4 below limit no fault", f_ocp, 0);
    run_cycle(5, NONE);
    chk("R4 fault at limit", f_ocp, 1);
    chk("R11 inhibit with fault", inh_ocp, 1);
    chk("R4 count at trip", cnt_ocp, 2);
    run_cycle(NONE, NONE);
    run_cycle(NONE, NONE);
    chk("R9 latched fault held", f_ocp, 1);
    chk("R9 count frozen", cnt_ocp, 2);
    chk("R11 inhibit held", inh_ocp, 1);

    // timed restart: R10 (tick fast 4, slow 16)
    restart_case(6'd3, 1'b0, 13, "fast");
    restart_case(6'd3, 1'b1, 49, "slow");
    restart_case(6'd0, 1'b0, 1, "zero");

    // disabled monitor: R1
    do_reset(1'b1, 3'd1, 1'b0, 6'd0, 1'b0);
    run_cycle(5, NONE);
    run_cycle(5, NONE);
    chk("R1 disabled count", cnt_ocp, 0);
    chk("R1 disabled no fault", f_ocp, 0);
    chk("R11 disabled no inhibit", inh_ocp, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule